// File: doc/BRIEF.md
# Banked Control Register File

This block holds the control state of a small processor core: the status byte with its stack-mode bit, a backup status byte, a second-level backup status byte, a separate condition bit, two backup program counters, two spare words and the saved copy of whichever stack pointer is not in use. The stack pointer that is in use is not held here. It lives in the general-register file, and the block reaches it through a read input and a write-enable/data output pair.

Control registers are selected by a register number on a combinational read port and a clocked write port. The number map is 0 status, 1 condition bit, 2 interrupt stack pointer, 3 user stack pointer, 4 and 5 spare, 6 backup PC, 7 second-level backup status and 8 second-level backup PC. All other numbers are unused. Access to either stack-pointer number goes to the live general-register copy or to the saved slot, depending on the stack-mode bit. A status write that flips that bit swaps the two copies in the same clock edge.

Top module: `ctl_regfile`

## Requirements
- R1: Reading register 0 returns, zero-extended, the backup status byte ANDed with 0xC1 in bits 15:8, the status byte ANDed with 0xC0 in bits 7:0, and the condition bit in bit 0.
- R2: A write to register 0 loads write bits 15:8 into the backup status byte and bits 7:0 into the status byte, and write bit 0 also sets the condition bit. Status bit 7 is the stack-mode bit.
- R3: When a register 0 write changes the stack-mode bit from 1 to 0, the live stack pointer is stored into the user slot and the interrupt slot is written to the live stack pointer, both at the same edge.
- R4: When a register 0 write changes the stack-mode bit from 0 to 1, the live stack pointer is stored into the interrupt slot and the user slot is written to the live stack pointer, both at the same edge.
- R5: With the stack-mode bit at 0, register 2 reads and writes the live stack pointer and register 3 reads and writes the user slot. With it at 1, register 3 reads and writes the live stack pointer and register 2 reads and writes the interrupt slot. The live-pointer write port is driven only in these cases and in R3/R4.
- R6: Registers 6 and 8 store all 32 written bits and read back with bit 0 forced to 0.
- R7: Register 7 stores write bits 7:0 and reads back ANDed with 0xC1. Register 1 writes and reads only bit 0, which is the same condition bit as in R1.
- R8: Registers 4 and 5 are plain 32-bit storage. Register numbers 9 to 15 read as zero, and writes to them change no state and drive no live-pointer write.
- R9: A synchronous reset clears every held register, including the stack-mode bit, and suppresses the live-pointer write.
- R10: Writes take effect at the rising edge. A read of the register being written in the same cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_sel | input | AW | Register number for the read port |
| rd_data | output | DW | Combinational read data |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | AW | Register number for the write port |
| wr_data | input | DW | Write data |
| gsp_q | input | DW | Current live stack pointer from the general-register file |
| gsp_we | output | 1 | Write enable for the live stack pointer |
| gsp_d | output | DW | Data for the live stack pointer |

## Verification
Every cycle, the assertions check the fixed zero bits of the status read, that the stack-mode bit follows each status write, that a mode flip places the old live pointer into the correct slot, that a live-pointer write comes only from a write to a register, that backup PCs read even, and that unused numbers read zero and never touch the live pointer. Only the bench scenarios can show the data values through the redirection: which copy register 2 or 3 returns before and after a swap, the masked read-back of each field, the condition bit shared between registers 0 and 1, old-value reads during a write, and the state left after a reset.

// File: rtl/ctl_regfile.sv
module ctl_regfile #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_sel,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] gsp_q,
  output logic          gsp_we,
  output logic [DW-1:0] gsp_d
);

  localparam logic [AW-1:0] N_STAT = AW'(0);
  localparam logic [AW-1:0] N_COND = AW'(1);
  localparam logic [AW-1:0] N_ISP  = AW'(2);
  localparam logic [AW-1:0] N_USP  = AW'(3);
  localparam logic [AW-1:0] N_SPA  = AW'(4);
  localparam logic [AW-1:0] N_SPB  = AW'(5);
  localparam logic [AW-1:0] N_BPC  = AW'(6);
  localparam logic [AW-1:0] N_BK2  = AW'(7);
  localparam logic [AW-1:0] N_BPC2 = AW'(8);
  localparam logic [7:0]    M_STAT = 8'hC0;
  localparam logic [7:0]    M_BK   = 8'hC1;
  localparam logic [DW-1:0] EVEN   = ~DW'(1);

  logic [7:0]    stat_q, bk_q, bk2_q;
  logic          cond_q;
  logic [DW-1:0] bpc_q, bpc2_q, spa_q, spb_q, isp_q, usp_q;

  wire sm     = stat_q[7];
  wire w_stat = wr_en && wr_sel == N_STAT;
  wire w_isp  = wr_en && wr_sel == N_ISP;
  wire w_usp  = wr_en && wr_sel == N_USP;
  wire flip   = w_stat && (wr_data[7] != sm);

  assign gsp_we = !rst && (flip || (w_isp && !sm) || (w_usp && sm));
  assign gsp_d  = flip ? (sm ? isp_q : usp_q) : wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      bk_q   <= '0;
      bk2_q  <= '0;
      cond_q <= 1'b0;
      bpc_q  <= '0;
      bpc2_q <= '0;
      spa_q  <= '0;
      spb_q  <= '0;
      isp_q  <= '0;
      usp_q  <= '0;
    end else begin
      if (w_stat) begin
        bk_q   <= wr_data[15:8];
        stat_q <= wr_data[7:0];
      end
      if (w_stat || (wr_en && wr_sel == N_COND))
        cond_q <= wr_data[0];
      if (flip && !sm)
        isp_q <= gsp_q;
      else if (w_isp && sm)
        isp_q <= wr_data;
      if (flip && sm)
        usp_q <= gsp_q;
      else if (w_usp && !sm)
        usp_q <= wr_data;
      if (wr_en) begin
        case (wr_sel)
          N_SPA:   spa_q  <= wr_data;
          N_SPB:   spb_q  <= wr_data;
          N_BPC:   bpc_q  <= wr_data;
          N_BK2:   bk2_q  <= wr_data[7:0];
          N_BPC2:  bpc2_q <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_sel)
      N_STAT:  rd_data = DW'({bk_q & M_BK, (stat_q & M_STAT) | {7'b0, cond_q}});
      N_COND:  rd_data = DW'(cond_q);
      N_ISP:   rd_data = sm ? isp_q : gsp_q;
      N_USP:   rd_data = sm ? gsp_q : usp_q;
      N_SPA:   rd_data = spa_q;
      N_SPB:   rd_data = spb_q;
      N_BPC:   rd_data = bpc_q & EVEN;
      N_BK2:   rd_data = DW'(bk2_q & M_BK);
      N_BPC2:  rd_data = bpc2_q & EVEN;
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/ctl_regfile_chk.sv
module ctl_regfile_chk #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] rd_sel,
  input logic [DW-1:0] rd_data,
  input logic          wr_en,
  input logic [AW-1:0] wr_sel,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] gsp_q,
  input logic          gsp_we,
  input logic [DW-1:0] gsp_d,
  input logic          sm,
  input logic [DW-1:0] isp_q,
  input logic [DW-1:0] usp_q
);

  wire stat_wr = wr_en && wr_sel == AW'(0);

  p_status_fmt_r1: assert property (@(posedge clk) disable iff (rst)
    rd_sel == AW'(0) |-> (rd_data[DW-1:16] == '0 && rd_data[13:9] == '0 && rd_data[5:1] == '0));

  p_mode_load_r2: assert property (@(posedge clk) disable iff (rst)
    stat_wr |=> sm == $past(wr_data[7]));

  p_swap_down_r3: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && sm && !wr_data[7]) |=> usp_q == $past(gsp_q));

  p_swap_up_r4: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !sm && wr_data[7]) |=> isp_q == $past(gsp_q));

  p_live_src_r5: assert property (@(posedge clk) disable iff (rst)
    gsp_we |-> wr_en);

  p_live_isp_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == AW'(2) && !sm) |-> (gsp_we && gsp_d == wr_data));

  p_bpc_even_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == AW'(6) || rd_sel == AW'(8)) |-> !rd_data[0]);

  p_unused_rd_r8: assert property (@(posedge clk) disable iff (rst)
    rd_sel > AW'(8) |-> rd_data == '0);

  p_unused_wr_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel > AW'(8)) |-> !gsp_we);

endmodule

bind ctl_regfile ctl_regfile_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .rd_sel(rd_sel), .rd_data(rd_data),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .gsp_q(gsp_q), .gsp_we(gsp_we), .gsp_d(gsp_d),
  .sm(stat_q[7]), .isp_q(isp_q), .usp_q(usp_q)
);

// File: tb/test_ctl_regfile.sv
module test_ctl_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rd_sel = '0, wr_sel = '0;
  logic [31:0] rd_data, wr_data = '0, gsp_d;
  logic        wr_en = 1'b0, gsp_we;
  logic [31:0] gsp = 32'h0000_1234;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0]  m_stat = 0, m_bk = 0, m_bk2 = 0;
  logic        m_cond = 0;
  logic [31:0] m_bpc = 0, m_bpc2 = 0, m_s4 = 0, m_s5 = 0, m_isp = 0, m_usp = 0;

  always #5 clk = ~clk;

  ctl_regfile i_ctl_regfile (
    .clk(clk), .rst(rst), .rd_sel(rd_sel), .rd_data(rd_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .gsp_q(gsp), .gsp_we(gsp_we), .gsp_d(gsp_d)
  );

  function automatic logic [31:0] exp_rd(input logic [3:0] s);
    case (s)
      0: return {16'h0, m_bk & 8'hC1, (m_stat & 8'hC0) | {7'b0, m_cond}};
      1: return {31'b0, m_cond};
      2: return m_stat[7] ? m_isp : gsp;
      3: return m_stat[7] ? gsp : m_usp;
      4: return m_s4;
      5: return m_s5;
      6: return m_bpc & 32'hFFFF_FFFE;
      7: return {24'b0, m_bk2 & 8'hC1};
      8: return m_bpc2 & 32'hFFFF_FFFE;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [3:0] s);
    case (s)
      0: return "R1";
      1, 7: return "R7";
      2, 3: return "R5";
      6, 8: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic we, input logic [3:0] ws, input logic [31:0] wd,
                      input logic [3:0] rs, input logic r, input string tag = "",
                      input logic poke = 0, input logic [31:0] pv = 0);
    logic flip, sm, e_we;
    logic [31:0] e_d, sp0;
    @(negedge clk);
    if (poke) gsp = pv;
    rst = r; wr_en = we; wr_sel = ws; wr_data = wd; rd_sel = rs;
    #1;
    sm   = m_stat[7];
    sp0  = gsp;
    flip = we && ws == 0 && wd[7] != sm;
    e_we = !r && (flip || (we && ws == 2 && !sm) || (we && ws == 3 && sm));
    e_d  = flip ? (sm ? m_isp : m_usp) : wd;
    if (!r) chk(tag != "" ? tag : rd_tag(rs), rd_data, exp_rd(rs));
    chk(flip ? (sm ? "R3 live write" : "R4 live write") : (r ? "R9 live write" : "R5 live write"),
        {31'b0, gsp_we}, {31'b0, e_we});
    if (e_we) chk(flip ? (sm ? "R3 live data" : "R4 live data") : "R5 live data", gsp_d, e_d);
    @(posedge clk);
    if (r) begin
      m_stat = 0; m_bk = 0; m_bk2 = 0; m_cond = 0;
      m_bpc = 0; m_bpc2 = 0; m_s4 = 0; m_s5 = 0; m_isp = 0; m_usp = 0;
    end else if (we) begin
      case (ws)
        0: begin
          m_bk = wd[15:8]; m_stat = wd[7:0]; m_cond = wd[0];
          if (flip) begin
            if (sm) m_usp = sp0; else m_isp = sp0;
          end
        end
        1: m_cond = wd[0];
        2: if (sm) m_isp = wd;
        3: if (!sm) m_usp = wd;
        4: m_s4 = wd;
        5: m_s5 = wd;
        6: m_bpc = wd;
        7: m_bk2 = wd[7:0];
        8: m_bpc2 = wd;
        default: ;
      endcase
    end
    if (e_we) gsp <= e_d;
  endtask

  task automatic rd(input logic [3:0] s, input string tag = "");
    step(0, 0, 0, s, 0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(1, 0, 32'hFFFF, 0, 1);
    step(1, 6, 32'h55, 6, 1);
    for (int s = 0; s < 16; s++) rd(4'(s), "R9 reset state");

    step(1, 0, 32'h0000_FFFF, 3, 0, "R2");
    rd(0, "R1 status fields");
    rd(2, "R4 interrupt slot after swap");
    rd(3, "R4 live pointer after swap");
    step(1, 3, 32'h000A_AAA0, 0, 0);
    step(1, 2, 32'h0000_5555, 3, 0);
    rd(2, "R5 interrupt slot");
    rd(3, "R5 live user pointer");
    step(1, 0, 32'h0000_4102, 0, 0, "R2");
    rd(3, "R3 user slot after swap");
    rd(2, "R3 live pointer after swap");
    rd(0, "R1 status cond cleared");
    step(1, 0, 32'h0000_0003, 0, 0, "R2 no flip");
    step(1, 1, 32'hFFFF_FFFE, 0, 0);
    rd(0, "R7 cond shared with status");
    step(1, 1, 32'h3, 1, 0);
    rd(1, "R7 cond bit");
    step(1, 6, 32'hDEAD_BEEF, 6, 0, "R10 same-cycle read");
    rd(6, "R6 backup pc");
    step(1, 8, 32'h1357_9BDF, 8, 0);
    rd(8, "R6 second backup pc");
    step(1, 7, 32'hFFFF_FFFF, 7, 0);
    rd(7, "R7 second backup status");
    step(1, 4, 32'hCAFE_F00D, 5, 0);
    step(1, 5, 32'h0BAD_CAFE, 4, 0, "R8 spare");
    rd(5, "R8 spare");
    for (int s = 9; s < 16; s++) step(1, 4'(s), 32'hFFFF_FFFF, 4'(s), 0);
    for (int s = 0; s < 16; s++) rd(4'(s), "R8 after unused writes");
    step(1, 2, 32'h2468_ACE0, 2, 0, "R10 live same-cycle");
    rd(2, "R10 live after write");

    for (int i = 0; i < 4000; i++) begin
      logic [3:0] ws;
      ws = ($urandom % 3 == 0) ? 4'($urandom % 4) : 4'($urandom);
      step($urandom % 2 == 0, ws, $urandom, 4'($urandom), $urandom % 300 == 0, "",
           $urandom % 40 == 0, $urandom);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule